// File: doc/BRIEF.md
# Crystal and PLL Power Sequencer

This block powers an on-board crystal oscillator and the PLL that follows it through two general-purpose control outputs. It holds a value register and an output-enable register for those two lines. A requester asks for power on or power off and gives a two-bit mask that picks the crystal, the PLL or both. The block then steps the outputs in a safe order and waits for the crystal and the PLL to settle. The waits are cycle counts derived from the clock-rate parameter `CLK_HZ`: 1 ms is `CLK_HZ/1000` cycles and 5 ms is `5*CLK_HZ/1000` cycles.

The PLL line is a power-down control, so a 1 on it holds the PLL off. During power-up the block first raises the crystal line and holds the PLL down. After the crystal wait it releases the PLL. If the crystal readback input already shows the oscillator running, the block changes no output, so a clock that is in use is not disturbed. Every power-on request ends with a one-cycle pulse that clears an external sticky target-abort status flag. Power-off requests finish at once.

Top module: `xtal_pll_seq`

## Requirements
- R1: After a synchronous active-low reset, `ctl_out` and `ctl_oe` are 0, and `busy`, `done` and `abort_clr` are 0.
- R2: Mask bit 0 selects the crystal and mask bit 1 selects the PLL, and output bits use the same positions. Every accepted request, on or off, ORs the mask into `ctl_oe`, and the new value shows in the cycle after acceptance.
- R3: On a power-on request with `xtal_sense` low and the crystal selected, `ctl_out[0]` becomes 1 in the cycle after acceptance. If the PLL is also selected, `ctl_out[1]` becomes 1 in that same cycle. The block then waits `CLK_HZ/1000` cycles.
- R4: On a power-on request with `xtal_sense` low and the PLL selected, `ctl_out[1]` is cleared to 0 and a wait of `5*CLK_HZ/1000` cycles follows. The clear happens after the crystal wait when the crystal is selected, and in the cycle after acceptance when it is not.
- R5: On a power-on request with `xtal_sense` high, `ctl_out` does not change, and `done` and `abort_clr` are high in the cycle after acceptance.
- R6: `abort_clr` is high for exactly one cycle at the end of every power-on sequence, in the same cycle as `done`, including skipped ones. It is never high for a power-off request.
- R7: On a power-off request, `ctl_out[0]` is cleared if the crystal is selected and `ctl_out[1]` is set if the PLL is selected. There is no wait, and `done` is high in the cycle after acceptance.
- R8: A request is accepted only while `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle. A request made while `busy` is high changes nothing.
- R9: `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_on | input | 1 | 1 = power up, 0 = power down |
| req_mask | input | 2 | Bit 0 crystal, bit 1 PLL |
| xtal_sense | input | 1 | Readback of the crystal power line, high when the oscillator is running |
| ctl_out | output | 2 | Output value register: bit 0 crystal on, bit 1 PLL power-down |
| ctl_oe | output | 2 | Output-enable register |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| abort_clr | output | 1 | One-cycle pulse that clears the sticky target-abort flag |

## Verification
The output and enable changes on acceptance are due one cycle after the accepting edge. The PLL release is due exactly `CLK_HZ/1000` cycles later, and the `done` pulse follows the last wait by one more cycle. A full crystal-plus-PLL power-up therefore keeps `busy` high for `1 + CLK_HZ/1000 + 5*CLK_HZ/1000` cycles. The bench drives inputs on the falling edge and advances its reference model on the rising edge, so the model counts the same waits. It compares every output against the model on each falling edge, and it also measures the length of each `busy` window against those totals.

// File: rtl/xps_pkg.sv
// Shared definitions for the crystal/PLL power sequencer.
// Assumes two control lines: index 0 crystal, index 1 PLL power-down.
package xps_pkg;
    localparam int XTAL_IDX = 0;
    localparam int PLL_IDX  = 1;
    localparam int NLINES   = 2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_XWAIT   = 3'd1,
        ST_PWAIT   = 3'd2,
        ST_ON_END  = 3'd3,
        ST_OFF_END = 3'd4
    } seq_state_t;

    // Cycles in a delay of the given number of milliseconds.
    function automatic longint unsigned ms_cycles(longint unsigned clk_hz, int unsigned ms);
        return (clk_hz * ms) / 1000;
    endfunction
endpackage

// File: rtl/xps_timer.sv
// Down-counting settle timer. Loaded with (delay - 1); expired is high
// while the count is zero. Assumes load values fit in CW bits.
module xps_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    // Count down toward zero, reloading on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/xps_shadow.sv
// Shadow registers for the control-line value and output enable.
// Assumes set and clear of one bit are never requested together;
// set wins if they are.
module xps_shadow #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_bits,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] oe_or,
    output logic [N-1:0] val_q,
    output logic [N-1:0] oe_q
);
    for (genvar i = 0; i < N; i++) begin : g_line
        // Per-line value register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q[i] <= 1'b0;
            else if (set_bits[i])
                val_q[i] <= 1'b1;
            else if (clr_bits[i])
                val_q[i] <= 1'b0;
        end

        // Per-line enable register, only ever widened by requests.
        always_ff @(posedge clk) begin
            if (!rst_n)
                oe_q[i] <= 1'b0;
            else if (oe_or[i])
                oe_q[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/xps_ctrl.sv
// Sequencing FSM: accepts a request when idle, issues line set/clear
// commands and timer loads, and walks the crystal and PLL waits.
// Assumes the timer reports expired one cycle after a load of 0.
module xps_ctrl
    import xps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_on,
    input  logic [NLINES-1:0] req_mask,
    input  logic              xtal_sense,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic              tmr_long,
    output logic [NLINES-1:0] set_bits,
    output logic [NLINES-1:0] clr_bits,
    output logic [NLINES-1:0] oe_or,
    output seq_state_t        state_q
);
    seq_state_t state_d;
    logic       pll_sel_q;

    // State register and PLL-selected flag captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pll_sel_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid)
                pll_sel_q <= req_mask[PLL_IDX];
        end
    end

    // Next state and command decode.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_long = 1'b0;
        set_bits = '0;
        clr_bits = '0;
        oe_or    = '0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    oe_or = req_mask;
                    if (req_on) begin
                        if (!xtal_sense && req_mask[XTAL_IDX]) begin
                            set_bits[XTAL_IDX] = 1'b1;
                            set_bits[PLL_IDX]  = req_mask[PLL_IDX];
                            tmr_load = 1'b1;
                            state_d  = ST_XWAIT;
                        end else if (!xtal_sense && req_mask[PLL_IDX]) begin
                            clr_bits[PLL_IDX] = 1'b1;
                            tmr_load = 1'b1;
                            tmr_long = 1'b1;
                            state_d  = ST_PWAIT;
                        end else begin
                            state_d = ST_ON_END;
                        end
                    end else begin
                        clr_bits[XTAL_IDX] = req_mask[XTAL_IDX];
                        set_bits[PLL_IDX]  = req_mask[PLL_IDX];
                        state_d = ST_OFF_END;
                    end
                end
            end
            ST_XWAIT: begin
                if (tmr_expired) begin
                    if (pll_sel_q) begin
                        clr_bits[PLL_IDX] = 1'b1;
                        tmr_load = 1'b1;
                        tmr_long = 1'b1;
                        state_d  = ST_PWAIT;
                    end else begin
                        state_d = ST_ON_END;
                    end
                end
            end
            ST_PWAIT:   if (tmr_expired) state_d = ST_ON_END;
            ST_ON_END:  state_d = ST_IDLE;
            ST_OFF_END: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/xtal_pll_seq.sv
// Crystal and PLL power sequencer top. Bit 0 of the lines is crystal
// power (active high), bit 1 is PLL power-down (active high).
// Assumes CLK_HZ >= 1000 so both waits are at least one cycle.
module xtal_pll_seq
    import xps_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 100_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_on,
    input  logic [1:0] req_mask,
    input  logic       xtal_sense,
    output logic [1:0] ctl_out,
    output logic [1:0] ctl_oe,
    output logic       busy,
    output logic       done,
    output logic       abort_clr
);
    localparam longint unsigned XTAL_CYC = ms_cycles(CLK_HZ, 1);
    localparam longint unsigned PLL_CYC  = ms_cycles(CLK_HZ, 5);
    localparam int CW = (PLL_CYC > 1) ? $clog2(PLL_CYC) : 1;
    localparam logic [CW-1:0] XTAL_LOAD = CW'(XTAL_CYC - 1);
    localparam logic [CW-1:0] PLL_LOAD  = CW'(PLL_CYC - 1);

    logic              tmr_load, tmr_long, tmr_expired;
    logic [NLINES-1:0] set_bits, clr_bits, oe_or;
    seq_state_t        state_q;

    xps_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_on     (req_on),
        .req_mask   (req_mask),
        .xtal_sense (xtal_sense),
        .tmr_expired(tmr_expired),
        .tmr_load   (tmr_load),
        .tmr_long   (tmr_long),
        .set_bits   (set_bits),
        .clr_bits   (clr_bits),
        .oe_or      (oe_or),
        .state_q    (state_q)
    );

    xps_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_long ? PLL_LOAD : XTAL_LOAD),
        .expired (tmr_expired)
    );

    xps_shadow #(.N(NLINES)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_bits(set_bits),
        .clr_bits(clr_bits),
        .oe_or   (oe_or),
        .val_q   (ctl_out),
        .oe_q    (ctl_oe)
    );

    // Status decode from the registered state.
    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_ON_END) || (state_q == ST_OFF_END);
    assign abort_clr = (state_q == ST_ON_END);
endmodule

// File: rtl/xps_checker.sv
// Port-level properties of the sequencer, bound to every instance.
module xps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_on,
    input logic [1:0] req_mask,
    input logic       xtal_sense,
    input logic [1:0] ctl_out,
    input logic [1:0] ctl_oe,
    input logic       busy,
    input logic       done,
    input logic       abort_clr
);
    // R2
    oe_covers_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> ((ctl_oe & $past(req_mask)) == $past(req_mask)));
    // R5
    running_xtal_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_on && xtal_sense) |=> (done && abort_clr && $stable(ctl_out)));
    // R6
    abort_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_clr |-> done);
    // R7
    off_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !req_on) |=> (done && !abort_clr));
    // R8
    busy_holds_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctl_oe));
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind xtal_pll_seq xps_checker u_xps_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_on    (req_on),
    .req_mask  (req_mask),
    .xtal_sense(xtal_sense),
    .ctl_out   (ctl_out),
    .ctl_oe    (ctl_oe),
    .busy      (busy),
    .done      (done),
    .abort_clr (abort_clr)
);

// File: tb/tb_xtal_pll_seq.sv
module tb_xtal_pll_seq;
    localparam int CLK_PERIOD = 10;
    localparam longint unsigned TB_HZ = 20_000;
    localparam int T_X = 20;   // 1 ms at TB_HZ
    localparam int T_P = 100;  // 5 ms at TB_HZ

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_on = 1'b0;
    logic [1:0] req_mask = 2'b00;
    logic       xtal_sense = 1'b0;
    logic [1:0] ctl_out, ctl_oe;
    logic       busy, done, abort_clr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xtal_pll_seq #(.CLK_HZ(TB_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
        .req_mask(req_mask), .xtal_sense(xtal_sense), .ctl_out(ctl_out),
        .ctl_oe(ctl_oe), .busy(busy), .done(done), .abort_clr(abort_clr)
    );

    // Behavioural reference: phase 0 idle, 1 crystal settle, 2 PLL settle,
    // 3 power-on finish, 4 power-off finish.
    int         m_phase = 0;
    int         m_left = 0;
    bit         m_pll = 0;
    logic [1:0] m_out = 2'b00;
    logic [1:0] m_oe = 2'b00;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_out = 2'b00; m_oe = 2'b00;
        end else if (m_phase == 3 || m_phase == 4) begin
            m_phase = 0;
        end else if (m_phase == 1) begin
            m_left = m_left - 1;
            if (m_left == 0) begin
                if (m_pll) begin m_out[1] = 1'b0; m_phase = 2; m_left = T_P; end
                else m_phase = 3;
            end
        end else if (m_phase == 2) begin
            m_left = m_left - 1;
            if (m_left == 0) m_phase = 3;
        end else if (req_valid) begin
            m_oe = m_oe | req_mask;
            m_pll = req_mask[1];
            if (!req_on) begin
                if (req_mask[0]) m_out[0] = 1'b0;
                if (req_mask[1]) m_out[1] = 1'b1;
                m_phase = 4;
            end else if (xtal_sense || req_mask == 2'b00) begin
                m_phase = 3;
            end else if (req_mask[0]) begin
                m_out[0] = 1'b1;
                if (req_mask[1]) m_out[1] = 1'b1;
                m_phase = 1; m_left = T_X;
            end else begin
                m_out[1] = 1'b0;
                m_phase = 2; m_left = T_P;
            end
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (ctl_out !== m_out) begin
                failures++;
                $display("FAIL R3/R4/R7 ctl_out actual=%b expected=%b t=%0t", ctl_out, m_out, $time);
            end
            if (ctl_oe !== m_oe) begin
                failures++;
                $display("FAIL R2 ctl_oe actual=%b expected=%b t=%0t", ctl_oe, m_oe, $time);
            end
            if (busy !== (m_phase != 0)) begin
                failures++;
                $display("FAIL R8 busy actual=%b expected=%b t=%0t", busy, (m_phase != 0), $time);
            end
            if (done !== (m_phase >= 3)) begin
                failures++;
                $display("FAIL R9 done actual=%b expected=%b t=%0t", done, (m_phase >= 3), $time);
            end
            if (abort_clr !== (m_phase == 3)) begin
                failures++;
                $display("FAIL R6 abort_clr actual=%b expected=%b t=%0t", abort_clr, (m_phase == 3), $time);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=%0d expected<=50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One-cycle request; returns at the falling edge after acceptance.
    task automatic request(input bit on, input logic [1:0] mask);
        @(negedge clk);
        req_valid = 1'b1; req_on = on; req_mask = mask;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Count the cycles busy stays high, starting at the current falling edge.
    task automatic busy_len(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ctl_out", ctl_out, 0);
        check("R1 ctl_oe", ctl_oe, 0);
        check("R1 busy/done/abort_clr", {busy, done, abort_clr}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 and R4: full power-up, PLL held down during crystal settle
        request(1'b1, 2'b11);
        check("R3 crystal and PLL-down set", ctl_out, 3);
        // R8: a request while busy is ignored
        request(1'b0, 2'b11);
        check("R8 ignored request while busy", ctl_out, 3);
        busy_len(n);
        check("R4 busy window crystal+PLL", n + 2, 1 + T_X + T_P);
        check("R4 PLL released", ctl_out, 1);

        // R7 off PLL only
        request(1'b0, 2'b10);
        check("R7 PLL power-down set", ctl_out, 3);
        check("R7 done immediately", done, 1);
        @(negedge clk);

        // R4 PLL only power-up
        request(1'b1, 2'b10);
        check("R4 PLL cleared at once", ctl_out, 1);
        busy_len(n);
        check("R4 busy window PLL only", n, 1 + T_P);

        // R7 off crystal only
        request(1'b0, 2'b01);
        check("R7 crystal cleared", ctl_out, 0);
        @(negedge clk);

        // R5 crystal already running: nothing changes
        xtal_sense = 1'b1;
        request(1'b1, 2'b11);
        check("R5 outputs unchanged", ctl_out, 0);
        check("R5 done and abort_clr", {done, abort_clr}, 3);
        xtal_sense = 1'b0;
        @(negedge clk);

        // R6 empty mask power-on still clears abort flag
        request(1'b1, 2'b00);
        check("R6 abort_clr on empty mask", abort_clr, 1);
        @(negedge clk);

        // R3 crystal only power-up
        request(1'b1, 2'b01);
        check("R3 crystal only", ctl_out, 1);
        busy_len(n);
        check("R3 busy window crystal only", n, 1 + T_X);

        // R7 off both, R2 enable kept
        request(1'b0, 2'b11);
        check("R7 both off", ctl_out, 2);
        check("R2 enable both", ctl_oe, 3);
        repeat (3) @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule